// File: doc/BRIEF.md
# Complementary Buzzer Frequency Generator

This peripheral makes a square-wave tone and drives it onto two pins that are shared with general-purpose I/O. Three clock-enable sources can pace the tone: a low-speed crystal tick, a low-speed RC tick, or the system clock divided by four. That pace is the time base. The tone's half-period is a power of two of time-base ticks, set by a three-bit divide select. The tone has a 50% duty cycle.

A two-bit pin-mode field assigns the pins in one of three ways:

- both pins stay plain I/O;
- both pins carry the tone as a complementary pair for differential drive;
- only pin 0 carries the tone, and pin 1 stays plain I/O.

The port data bit of pin 0 works as the on/off switch for the tone on both pins. The port direction bits decide whether each pin is driven. All pin outputs and enables are registered.

Top module: `buzz_tone_top`

## Requirements
- R1: While synchronous reset `rst` is high, and in the cycle after it is released, all four pin outputs and enables are 0. The internal tone restarts low.
- R2: `src_sel` picks the time base: 00 is `xtal_tick`, 01 is `rc_tick`, 10 and 11 are one tick every 4 clock cycles.
- R3: With divide code k on `div_sel`, each tone half-period lasts 2^(k+1) time-base ticks. The full period is therefore 2^(k+2) ticks, with equal high and low time.
- R4: A new `div_sel` value is taken only when the tone toggles. The half-period in progress completes at its old length, and the following halves use the new length.
- R5: With `pin_mode` 00 or 11, pin n outputs `port_dat[n]`.
- R6: With `pin_mode` 01, pin 0 outputs `port_dat[0]` AND tone, and pin 1 outputs `port_dat[0]` AND NOT tone. While the tone is on, pin 1 is the inverse of pin 0.
- R7: With `pin_mode` 10, pin 0 outputs `port_dat[0]` AND tone, and pin 1 outputs `port_dat[1]`.
- R8: While `port_dat[0]` is 0, every pin in buzzer mode outputs 0.
- R9: In `pin_mode` 01, `port_dat[1]` has no effect on pin 1.
- R10: In every mode, `pinN_oe` equals NOT `port_dir[N]` (direction 0 means output). Every output reflects its inputs one clock after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick | input | 1 | Crystal time-base enable pulse |
| rc_tick | input | 1 | RC time-base enable pulse |
| src_sel | input | 2 | Time-base source select |
| div_sel | input | 3 | Divide code k, half-period 2^(k+1) ticks |
| pin_mode | input | 2 | Pin-sharing mode |
| port_dat | input | 2 | Port data bits of pins 0 and 1 |
| port_dir | input | 2 | Port direction bits, 1 means input |
| pin0_out | output | 1 | Pin 0 output value |
| pin0_oe | output | 1 | Pin 0 output enable |
| pin1_out | output | 1 | Pin 1 output value |
| pin1_oe | output | 1 | Pin 1 output enable |

## Verification
The tone is not a port, so checking the mux against every mode, data and direction pattern needs the tone held at a known level. The stimulus resets with the crystal source selected and no crystal ticks, which freezes the tone low. It then sends exactly two manual ticks at divide code 0, which freezes the tone high, and repeats the random mux patterns at that level. The glitch-free divide change is reached by syncing to a rising edge of the tone and switching `div_sel` in the middle of a long high phase.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
  typedef enum logic [1:0] {
    PM_GPIO   = 2'b00,
    PM_PAIR   = 2'b01,
    PM_SINGLE = 2'b10,
    PM_ALT    = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'b00,
    SRC_RC   = 2'b01,
    SRC_SYS  = 2'b10,
    SRC_SYSB = 2'b11
  } tb_src_e;

  localparam int SEL_W  = 3;
  localparam int N_MIN  = 2;
  localparam int N_PINS = 2;
endpackage

// File: rtl/buzz_timebase.sv
module buzz_timebase #(
  parameter int SYS_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       xtal_tick,
  input  logic       rc_tick,
  input  logic [1:0] src_sel,
  output logic       tb_tick
);
  import buzz_pkg::*;

  logic sys_tick;

  generate
    if (SYS_DIV > 1) begin : g_pre
      localparam int PW = $clog2(SYS_DIV);
      logic [PW-1:0] pre_cnt;
      always_ff @(posedge clk) begin
        if (rst) pre_cnt <= '0;
        else if (pre_cnt == PW'(SYS_DIV - 1)) pre_cnt <= '0;
        else pre_cnt <= pre_cnt + 1'b1;
      end
      assign sys_tick = (pre_cnt == PW'(SYS_DIV - 1));
    end else begin : g_nopre
      assign sys_tick = 1'b1;
    end
  endgenerate

  logic sel_tick;
  always_comb begin
    unique case (tb_src_e'(src_sel))
      SRC_XTAL: sel_tick = xtal_tick;
      SRC_RC:   sel_tick = rc_tick;
      default:  sel_tick = sys_tick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tb_tick <= 1'b0;
    else     tb_tick <= sel_tick;
  end

  generate
    if (SYS_DIV > 1) begin : g_chk
      p_sys_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        sys_tick |=> !sys_tick);
    end
  endgenerate
endmodule

// File: rtl/buzz_divider.sv
module buzz_divider
  import buzz_pkg::*;
#(
  parameter int DSEL_W = SEL_W,
  parameter int NMIN   = N_MIN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tb_tick,
  input  logic [DSEL_W-1:0] div_sel,
  output logic              tone
);
  localparam int CNT_W = NMIN + (1 << DSEL_W) - 2;

  logic [DSEL_W-1:0] act_sel;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W:0]    one_sh;
  logic [CNT_W-1:0]  half_m1;
  logic              wrap;

  always_comb begin
    one_sh  = (CNT_W+1)'(1) << (32'(act_sel) + NMIN - 1);
    half_m1 = CNT_W'(one_sh - 1'b1);
    wrap    = tb_tick && (cnt == half_m1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      tone    <= 1'b0;
      act_sel <= div_sel;
    end else if (tb_tick) begin
      if (wrap) begin
        cnt     <= '0;
        tone    <= ~tone;
        act_sel <= div_sel;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= half_m1);
  p_toggle_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !tb_tick |=> $stable(tone));
  p_sel_at_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_sel) |-> (tone != $past(tone)));
endmodule

// File: rtl/buzz_pinmux.sv
module buzz_pinmux
  import buzz_pkg::*;
#(
  parameter int NP = N_PINS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tone,
  input  logic [1:0]    pin_mode,
  input  logic [NP-1:0] port_dat,
  input  logic [NP-1:0] port_dir,
  output logic [NP-1:0] pin_out,
  output logic [NP-1:0] pin_oe
);
  logic [NP-1:0] nxt_out;

  always_comb begin
    nxt_out = port_dat;
    unique case (pin_mode_e'(pin_mode))
      PM_PAIR: begin
        nxt_out[0] = port_dat[0] & tone;
        nxt_out[1] = port_dat[0] & ~tone;
      end
      PM_SINGLE: nxt_out[0] = port_dat[0] & tone;
      default:   nxt_out = port_dat;
    endcase
  end

  for (genvar i = 0; i < NP; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[i] <= 1'b0;
        pin_oe[i]  <= 1'b0;
      end else begin
        pin_out[i] <= nxt_out[i];
        pin_oe[i]  <= ~port_dir[i];
      end
    end
    p_oe_dir_r10: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (pin_oe[i] == !$past(port_dir[i])));
  end

  p_pair_inverse_r6: assert property (@(posedge clk) disable iff (rst)
    (pin_mode == 2'b01 && port_dat[0]) |=> (pin_out[1] != pin_out[0]));
  p_gate_off_r8: assert property (@(posedge clk) disable iff (rst)
    (pin_mode == 2'b01 && !port_dat[0]) |=> (pin_out == '0));
  p_gpio_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (pin_mode == 2'b00) |=> (pin_out == $past(port_dat)));
endmodule

// File: rtl/buzz_tone_top.sv
module buzz_tone_top
  import buzz_pkg::*;
#(
  parameter int SYS_DIV = 4,
  parameter int DSEL_W  = SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xtal_tick,
  input  logic              rc_tick,
  input  logic [1:0]        src_sel,
  input  logic [DSEL_W-1:0] div_sel,
  input  logic [1:0]        pin_mode,
  input  logic [1:0]        port_dat,
  input  logic [1:0]        port_dir,
  output logic              pin0_out,
  output logic              pin0_oe,
  output logic              pin1_out,
  output logic              pin1_oe
);
  logic       tb_tick;
  logic       tone;
  logic [1:0] p_out;
  logic [1:0] p_oe;

  buzz_timebase #(.SYS_DIV(SYS_DIV)) u_tb (
    .clk(clk), .rst(rst), .xtal_tick(xtal_tick), .rc_tick(rc_tick),
    .src_sel(src_sel), .tb_tick(tb_tick)
  );

  buzz_divider #(.DSEL_W(DSEL_W), .NMIN(N_MIN)) u_div (
    .clk(clk), .rst(rst), .tb_tick(tb_tick), .div_sel(div_sel), .tone(tone)
  );

  buzz_pinmux #(.NP(2)) u_mux (
    .clk(clk), .rst(rst), .tone(tone), .pin_mode(pin_mode),
    .port_dat(port_dat), .port_dir(port_dir), .pin_out(p_out), .pin_oe(p_oe)
  );

  assign pin0_out = p_out[0];
  assign pin1_out = p_out[1];
  assign pin0_oe  = p_oe[0];
  assign pin1_oe  = p_oe[1];
endmodule

// File: tb/sim_buzz_tone_top.sv
module sim_buzz_tone_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xtal_tick = 1'b0;
  logic       rc_tick = 1'b0;
  logic [1:0] src_sel = 2'b10;
  logic [2:0] div_sel = 3'd0;
  logic [1:0] pin_mode = 2'b00;
  logic [1:0] port_dat = 2'b00;
  logic [1:0] port_dir = 2'b11;
  logic pin0_out, pin0_oe, pin1_out, pin1_oe;

  int errors = 0;
  int checks = 0;
  int xtal_per = 0;
  int rc_per = 0;
  int man_pulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  buzz_tone_top u0 (
    .clk(clk), .rst(rst), .xtal_tick(xtal_tick), .rc_tick(rc_tick),
    .src_sel(src_sel), .div_sel(div_sel), .pin_mode(pin_mode),
    .port_dat(port_dat), .port_dir(port_dir),
    .pin0_out(pin0_out), .pin0_oe(pin0_oe),
    .pin1_out(pin1_out), .pin1_oe(pin1_oe)
  );

  initial begin
    int xp = 0;
    int rp = 0;
    forever begin
      @(negedge clk);
      if (man_pulses > 0) begin
        xtal_tick = 1'b1;
        man_pulses--;
      end else if (xtal_per > 0) begin
        xp++;
        xtal_tick = (xp >= xtal_per);
        if (xp >= xtal_per) xp = 0;
      end else begin
        xtal_tick = 1'b0;
      end
      if (rc_per > 0) begin
        rp++;
        rc_tick = (rp >= rc_per);
        if (rp >= rc_per) rp = 0;
      end else begin
        rc_tick = 1'b0;
      end
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_out(input logic [1:0] m, input logic [1:0] d, input logic t);
    case (m)
      2'b01:   return {d[0] & ~t, d[0] & t};
      2'b10:   return {d[1], d[0] & t};
      default: return d;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Waits for a rising edge on pin 0, then returns the lengths of the high and low runs.
  task automatic measure(output int hi, output int lo);
    logic prev;
    @(negedge clk);
    prev = pin0_out;
    forever begin
      @(negedge clk);
      if (!prev && pin0_out) break;
      prev = pin0_out;
    end
    hi = 0;
    while (pin0_out) begin hi++; @(negedge clk); end
    lo = 0;
    while (!pin0_out) begin lo++; @(negedge clk); end
  endtask

  task automatic rand_mux(input logic t, input int n);
    for (int i = 0; i < n; i++) begin
      logic [1:0] m, d, r, e;
      m = 2'($urandom);
      d = 2'($urandom);
      r = 2'($urandom);
      @(negedge clk);
      pin_mode = m; port_dat = d; port_dir = r;
      @(posedge clk);
      @(negedge clk);
      e = exp_out(m, d, t);
      case (m)
        2'b01:   check({pin1_out, pin0_out} == e, "R6/R8/R9 pair", {pin1_out, pin0_out}, e);
        2'b10:   check({pin1_out, pin0_out} == e, "R7 single", {pin1_out, pin0_out}, e);
        default: check({pin1_out, pin0_out} == e, "R5 gpio", {pin1_out, pin0_out}, e);
      endcase
      check({pin1_oe, pin0_oe} == ~r, "R10 oe", {pin1_oe, pin0_oe}, ~r);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    int hi, lo;
    void'($urandom(32'd1357));

    // R1: reset state with buzzer mode requested
    pin_mode = 2'b01; port_dat = 2'b01; port_dir = 2'b00; src_sel = 2'b10;
    repeat (2) @(negedge clk);
    check({pin1_out, pin0_out, pin1_oe, pin0_oe} == 4'b0000, "R1 during reset",
          {pin1_out, pin0_out, pin1_oe, pin0_oe}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pin0_out == 1'b0, "R1 tone low after reset", pin0_out, 0);
    check(pin1_out == 1'b1 && pin0_oe && pin1_oe, "R1/R6 pair after reset",
          {pin1_out, pin0_oe, pin1_oe}, 3'b111);

    // R3: period sweep on the divide-by-4 system source
    for (int k = 0; k < 8; k++) begin
      div_sel = 3'(k);
      do_reset();
      measure(hi, lo);
      check(hi == 4 * (2 << k), "R3 high half", hi, 4 * (2 << k));
      check(lo == 4 * (2 << k), "R3 low half", lo, 4 * (2 << k));
    end

    // R6: complementary relation while the tone runs
    div_sel = 3'd1;
    do_reset();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i % 6 == 0) check(pin1_out == !pin0_out, "R6 inverse", pin1_out, !pin0_out);
    end

    // R8: data bit 0 low silences both buzzer pins
    port_dat = 2'b10;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i % 5 == 0) check({pin1_out, pin0_out} == 2'b00, "R8 gate off", {pin1_out, pin0_out}, 0);
    end
    port_dat = 2'b01;

    // R2: crystal source every 3 clocks and RC source every 5 clocks, code 1
    xtal_per = 3; rc_per = 5;
    src_sel = 2'b00; div_sel = 3'd1;
    do_reset();
    measure(hi, lo);
    check(hi == 12 && lo == 12, "R2 xtal source", hi, 12);
    src_sel = 2'b01;
    do_reset();
    measure(hi, lo);
    check(hi == 20 && lo == 20, "R2 rc source", hi, 20);
    src_sel = 2'b11;
    do_reset();
    measure(hi, lo);
    check(hi == 16 && lo == 16, "R2 code 11 uses sys/4", hi, 16);

    // R4: change divide code in the middle of a long high phase
    src_sel = 2'b10; div_sel = 3'd3;
    do_reset();
    measure(hi, lo);
    hi = 0;
    while (pin0_out) begin
      hi++;
      if (hi == 20) div_sel = 3'd0;
      @(negedge clk);
    end
    check(hi == 64, "R4 old half completes", hi, 64);
    lo = 0;
    while (!pin0_out) begin lo++; @(negedge clk); end
    check(lo == 8, "R4 new half applies", lo, 8);

    // R9: data bit 1 ignored on pin 1 in pair mode, tone frozen low
    xtal_per = 0; rc_per = 0;
    src_sel = 2'b00; div_sel = 3'd0;
    do_reset();
    pin_mode = 2'b01; port_dir = 2'b00;
    port_dat = 2'b01;
    repeat (2) @(negedge clk);
    check(pin1_out == 1'b1, "R9 dat1 low", pin1_out, 1);
    port_dat = 2'b11;
    repeat (2) @(negedge clk);
    check(pin1_out == 1'b1, "R9 dat1 high", pin1_out, 1);

    // R5/R6/R7/R10: random mux patterns with tone frozen low
    rand_mux(1'b0, 150);

    // Two manual ticks at code 0 flip the tone high, then freeze it
    man_pulses = 2;
    repeat (8) @(negedge clk);
    rand_mux(1'b1, 150);

    done = 1;
    report();
  end
endmodule